// File: doc/BRIEF.md
# Thread-tagged shared translation buffer

This block is a small, fully associative translation cache that two hardware threads share. There is one entry array, not one per thread. Each entry holds a virtual page number, a physical page number, a global flag, and the identity of the thread whose fill wrote it. A lookup request carries a thread identity and a virtual page. One cycle later it returns a hit flag and the physical page. An entry matches only the thread that installed it, and this holds for global entries too.

A fill port installs translations. A fill for a page the same thread already holds rewrites that entry. Otherwise the fill takes the lowest free slot. When no slot is free, a rotating pointer chooses the victim.

An invalidation port carries a thread identity, a kind code and a page. Each invalidation touches only entries tagged with the requesting thread. The kinds are:
- an address-space switch, which drops that thread's non-global entries;
- a paging-control change, which drops all of that thread's entries;
- a single-page invalidate, which drops that thread's entry for the given page.

Top module: `tlb_shared`

## Requirements
- R1: After synchronous reset, every entry is invalid, `rsp_valid` is low and every lookup misses.
- R2: `rsp_valid` is high exactly one cycle after `lk_valid`. The response reflects the entry state in the request cycle, so a fill or invalidation is visible to a lookup made in the following cycle. On a miss, `rsp_ppn` is zero.
- R3: A lookup hits only when a valid entry has the requested virtual page and a thread tag equal to the requesting thread. This also applies to entries whose global flag is set.
- R4: A fill whose thread and virtual page match a valid entry rewrites that entry's physical page and global flag. No second entry is created.
- R5: A fill with no matching entry is written into the lowest-index invalid entry, if one exists.
- R6: When all entries are valid, a non-matching fill replaces the entry chosen by a rotating pointer. The pointer is 0 after reset and advances by one, modulo the entry count, only on such replacing fills.
- R7: Invalidation kind 0 (address-space switch) removes the requesting thread's entries whose global flag is clear, and keeps its global entries.
- R8: Invalidation kind 1 (paging-control change) removes every entry of the requesting thread, global or not.
- R9: Invalidation kind 2 (single page) removes the requesting thread's entry whose virtual page equals `inv_vpn`, whether or not it is global, and no other entry.
- R10: No invalidation removes an entry tagged with the other thread. Kind code 3 removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_tid | input | 1 | Thread issuing the lookup |
| lk_vpn | input | 20 | Virtual page to translate |
| rsp_valid | output | 1 | Registered lookup response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | 20 | Physical page on a hit, zero on a miss |
| fill_valid | input | 1 | Install strobe |
| fill_tid | input | 1 | Thread installing the entry |
| fill_vpn | input | 20 | Virtual page of the new entry |
| fill_ppn | input | 20 | Physical page of the new entry |
| fill_global | input | 1 | Global flag of the new entry |
| inv_valid | input | 1 | Invalidation strobe |
| inv_tid | input | 1 | Thread requesting invalidation |
| inv_kind | input | 2 | 0 address-space switch, 1 paging change, 2 single page, 3 none |
| inv_vpn | input | 20 | Page for kind 2 |

## Verification
Several properties are checked on every cycle:
- the lookup response follows its request by exactly one cycle;
- a miss always returns a zero page;
- no two entries ever match the same thread and page;
- the other thread's entries survive any invalidation;
- global entries survive an address-space switch;
- a paging-control change empties the requesting thread's slots.

Other behaviour only shows through the bench's scenarios, where a behavioural model predicts every response:
- lowest-free slot placement;
- the order of the rotating pointer;
- rewriting an entry in place;
- single-page removal;
- the no-op kind code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int ENTRIES = 8;
    parameter int VPN_W   = 20;
    parameter int PPN_W   = 20;
    parameter int TID_W   = 1;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef enum logic [1:0] {
        INV_SPACE  = 2'd0,
        INV_PAGING = 2'd1,
        INV_PAGE   = 2'd2,
        INV_NONE   = 2'd3
    } inv_kind_e;

    typedef struct packed {
        logic             valid;
        logic             glb;
        logic [TID_W-1:0] tid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    // Decide whether an invalidation request removes one entry.
    function automatic logic inv_hits(input tlb_entry_t e,
                                      input logic [TID_W-1:0] tid,
                                      input inv_kind_e kind,
                                      input logic [VPN_W-1:0] vpn);
        logic own;
        own = e.valid && (e.tid == tid);
        case (kind)
            INV_SPACE:  return own && !e.glb;
            INV_PAGING: return own;
            INV_PAGE:   return own && (e.vpn == vpn);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  tlb_entry_t       ents [N],
    input  logic [TID_W-1:0] tid,
    input  logic [VPN_W-1:0] vpn,
    output logic [N-1:0]     hit_vec,
    output logic             any,
    output logic [IW-1:0]    idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].tid == tid) && (ents[g].vpn == vpn);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end

    assign any = |hit_vec;

    // R4: refills rewrite in place, so at most one entry matches a thread and page.
    p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid_vec,
    input  logic          advance,
    output logic          free_any,
    output logic [IW-1:0] free_idx,
    output logic [IW-1:0] rr_idx
);

    logic [IW-1:0] ptr_q;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    assign rr_idx = ptr_q;

    // R6: the rotating pointer holds still unless a replacing fill occurs.
    p_rr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(rr_idx));

    // R6: a replacing fill is only requested when no slot is free.
    p_rr_only_full_r6: assert property (@(posedge clk) disable iff (rst)
        advance |-> &valid_vec);

endmodule

// File: rtl/tlb_shared.sv
module tlb_shared
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [TID_W-1:0] lk_tid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    input  logic             fill_valid,
    input  logic [TID_W-1:0] fill_tid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_global,
    input  logic             inv_valid,
    input  logic [TID_W-1:0] inv_tid,
    input  logic [1:0]       inv_kind,
    input  logic [VPN_W-1:0] inv_vpn
);

    localparam int N  = ENTRIES;
    localparam int IW = IDX_W;

    tlb_entry_t        ents [N];
    logic [N-1:0]      valid_vec;
    logic [N-1:0]      lk_hits;
    logic [N-1:0]      fill_hits;
    logic              lk_any, fill_any, free_any, advance;
    logic [IW-1:0]     lk_idx, fill_idx, free_idx, rr_idx, fill_slot;
    inv_kind_e         kind;

    assign kind = inv_kind_e'(inv_kind);

    always_comb begin
        for (int i = 0; i < N; i++) valid_vec[i] = ents[i].valid;
    end

    tlb_match #(.N(N)) u_lk_match (
        .clk(clk), .rst(rst), .ents(ents), .tid(lk_tid), .vpn(lk_vpn),
        .hit_vec(lk_hits), .any(lk_any), .idx(lk_idx)
    );

    tlb_match #(.N(N)) u_fill_match (
        .clk(clk), .rst(rst), .ents(ents), .tid(fill_tid), .vpn(fill_vpn),
        .hit_vec(fill_hits), .any(fill_any), .idx(fill_idx)
    );

    tlb_victim #(.N(N)) u_victim (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .advance(advance),
        .free_any(free_any), .free_idx(free_idx), .rr_idx(rr_idx)
    );

    assign advance   = fill_valid && !fill_any && !free_any;
    assign fill_slot = fill_any ? fill_idx : (free_any ? free_idx : rr_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ents[i] <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any;
            rsp_ppn   <= (lk_valid && lk_any) ? ents[lk_idx].ppn : '0;
            if (inv_valid) begin
                for (int i = 0; i < N; i++) begin
                    if (inv_hits(ents[i], inv_tid, kind, inv_vpn)) ents[i].valid <= 1'b0;
                end
            end
            if (fill_valid) begin
                ents[fill_slot] <= '{valid: 1'b1, glb: fill_global, tid: fill_tid,
                                     vpn: fill_vpn, ppn: fill_ppn};
            end
        end
    end

    // R1: reset leaves no pending response.
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    // R2: a response follows each request by exactly one cycle.
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    p_rsp_none_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R2: a miss returns a zero page.
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));

    for (genvar g = 0; g < N; g++) begin : g_inv_chk
        // R10: the other thread's entries survive an invalidation.
        p_other_kept_r10: assert property (@(posedge clk) disable iff (rst)
            (inv_valid && !fill_valid && ents[g].valid && (ents[g].tid != inv_tid))
            |=> ents[g].valid);
        // R7: global entries survive an address-space switch.
        p_space_keeps_glb_r7: assert property (@(posedge clk) disable iff (rst)
            (inv_valid && !fill_valid && (kind == INV_SPACE) && ents[g].valid && ents[g].glb)
            |=> ents[g].valid);
        // R8: a paging change empties every slot of the requester.
        p_paging_drops_r8: assert property (@(posedge clk) disable iff (rst)
            (inv_valid && !fill_valid && (kind == INV_PAGING) && (ents[g].tid == inv_tid))
            |=> !ents[g].valid);
    end

endmodule

// File: tb/tlb_shared_tb.sv
module tlb_shared_tb;
    import tlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = ENTRIES;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lk_valid = 1'b0;
    logic [TID_W-1:0] lk_tid = '0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             rsp_valid, rsp_hit;
    logic [PPN_W-1:0] rsp_ppn;
    logic             fill_valid = 1'b0;
    logic [TID_W-1:0] fill_tid = '0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_global = 1'b0;
    logic             inv_valid = 1'b0;
    logic [TID_W-1:0] inv_tid = '0;
    logic [1:0]       inv_kind = 2'd3;
    logic [VPN_W-1:0] inv_vpn = '0;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural model
    bit m_v [N];
    int m_t [N];
    int m_vpn [N];
    int m_ppn [N];
    bit m_g [N];
    int m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_shared u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_global(fill_global),
        .inv_valid(inv_valid), .inv_tid(inv_tid), .inv_kind(inv_kind), .inv_vpn(inv_vpn)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0;
    endtask

    // One clock: predict from the model, advance the model, compare after the edge.
    task automatic tick();
        bit e_v, e_hit;
        int e_ppn;
        e_v = lk_valid; e_hit = 0; e_ppn = 0;
        if (lk_valid) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && m_t[i] == int'(lk_tid) && m_vpn[i] == int'(lk_vpn)) begin
                    e_hit = 1; e_ppn = m_ppn[i];
                end
            end
        end
        if (inv_valid) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && m_t[i] == int'(inv_tid)) begin
                    if (inv_kind == 2'd0 && !m_g[i]) m_v[i] = 0;
                    if (inv_kind == 2'd1) m_v[i] = 0;
                    if (inv_kind == 2'd2 && m_vpn[i] == int'(inv_vpn)) m_v[i] = 0;
                end
            end
        end
        if (fill_valid) begin
            int slot;
            slot = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_t[i] == int'(fill_tid) && m_vpn[i] == int'(fill_vpn)) slot = i;
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[slot] = 1; m_t[slot] = int'(fill_tid); m_vpn[slot] = int'(fill_vpn);
            m_ppn[slot] = int'(fill_ppn); m_g[slot] = fill_global;
        end
        @(posedge clk);
        #1;
        chk("rsp_valid", int'(rsp_valid), int'(e_v));
        if (e_v) begin
            chk("rsp_hit", int'(rsp_hit), int'(e_hit));
            chk("rsp_ppn", int'(rsp_ppn), e_ppn);
        end
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
        repeat (2) @(posedge clk);
        #1;
        rst = 0;
        model_clear();
        cur_req = "R1";
        chk("reset rsp_valid", int'(rsp_valid), 0);
        chk("reset rsp_hit", int'(rsp_hit), 0);
    endtask

    task automatic lookup(int tid, int vpn);
        lk_valid = 1; lk_tid = TID_W'(tid); lk_vpn = VPN_W'(vpn);
        tick();
    endtask

    task automatic fill(int tid, int vpn, int ppn, bit glb);
        fill_valid = 1; fill_tid = TID_W'(tid); fill_vpn = VPN_W'(vpn);
        fill_ppn = PPN_W'(ppn); fill_global = glb;
        tick();
    endtask

    task automatic inval(int tid, int kind, int vpn);
        inv_valid = 1; inv_tid = TID_W'(tid); inv_kind = 2'(kind); inv_vpn = VPN_W'(vpn);
        tick();
    endtask

    task automatic probe_all(int base, int cnt);
        for (int t = 0; t < 2; t++)
            for (int v = 0; v < cnt; v++) lookup(t, base + v);
    endtask

    // Load both threads: thread 0 pages 0x40..0x43, thread 1 pages 0x40..0x43, odd pages global.
    task automatic load_mix();
        for (int t = 0; t < 2; t++)
            for (int v = 0; v < 4; v++) fill(t, 'h40 + v, 'h1000 + t * 'h100 + v, bit'(v % 2));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        cur_req = "R1";
        lookup(0, 'h100);
        lookup(1, 'h0);

        cur_req = "R3";
        fill(0, 'h100, 'hA, 0);
        lookup(0, 'h100);
        lookup(1, 'h100);
        fill(1, 'h200, 'hB, 1);
        lookup(0, 'h200);
        lookup(1, 'h200);

        cur_req = "R4";
        fill(0, 'h100, 'hC, 1);
        lookup(0, 'h100);
        fill(1, 'h100, 'hD, 0);
        lookup(0, 'h100);
        lookup(1, 'h100);

        cur_req = "R2";
        lk_valid = 1; lk_tid = 0; lk_vpn = 'h100;
        tick();
        tick();
        tick();
        lookup(1, 'h999);

        cur_req = "R5";
        for (int v = 0; v < N - 3; v++) fill(v % 2, 'h300 + v, 'h2000 + v, 0);
        probe_all('h300, N - 3);
        inval(0, 2, 'h100);
        fill(1, 'h555, 'h5555, 0);
        lookup(1, 'h555);

        cur_req = "R6";
        for (int v = 0; v < N + 3; v++) begin
            fill(0, 'h600 + v, 'h3000 + v, 0);
            lookup(0, 'h600 + v);
        end
        probe_all('h600, N + 3);
        lookup(1, 'h200);

        do_reset();
        cur_req = "R7";
        load_mix();
        inval(0, 0, 0);
        probe_all('h40, 4);

        do_reset();
        cur_req = "R8";
        load_mix();
        inval(1, 1, 0);
        probe_all('h40, 4);

        do_reset();
        cur_req = "R9";
        load_mix();
        inval(0, 2, 'h41);
        probe_all('h40, 4);
        inval(1, 2, 'h42);
        probe_all('h40, 4);

        do_reset();
        cur_req = "R10";
        load_mix();
        inval(0, 3, 'h40);
        probe_all('h40, 4);
        inval(1, 1, 0);
        lookup(0, 'h40);
        lookup(0, 'h43);

        cur_req = "R2";
        inval(0, 2, 'h40);
        lookup(0, 'h40);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule